// File: doc/BRIEF.md
# Boot-Overlay Memory Decoder

This block sits on the system bus of a 32-bit processor and turns each transfer start into a decode result. The result is one of four: a ROM select, a select for one of four DRAM banks, a write to the decoder's own bank registers, or no response. The block then terminates the transfer with transfer-acknowledge pulses. Every ROM termination also carries transfer-burst-inhibit, so a burst request to ROM is refused. The processor then repeats the line as four single longword transfers. RAM bursts are acknowledged over four consecutive beats. The cache-inhibit output is held low, so all memory is cacheable.

After reset the block runs in boot overlay mode. The 1 MB ROM is aliased at the bottom of the address space and the DRAM banks are not decoded, so the processor can fetch its first instructions from address zero. The first transfer accepted in the normal ROM region (0x4000_0000 upward) ends the overlay for good. From then on, low addresses go to the DRAM banks. Software gives each bank a start and a size through a small write-only register window, so that the banks together form one contiguous space.

Top module: `memdec_top`

## Requirements
- R1: After reset the overlay is active, every bank has start 0 and size 0 (disabled), and `ta`, `tbi`, `rom_sel` and `bank_sel` are low.
- R2: While the overlay is active, an address whose upper 12 bits are zero selects ROM, with `rom_word` equal to address bits [19:2]. Any other address with bits [31:30] = 00 gets no acknowledge, and no bank is ever selected.
- R3: An accepted transfer whose address bits [31:28] equal 4 ends the overlay, and the overlay never returns until reset. From the next transfer on, address zero is decoded through the banks and no longer through ROM.
- R4: An address with bits [31:28] = 4 selects ROM, with `rom_word` equal to address bits [19:2], so the 1 MB ROM is mirrored across the region. Every ROM transfer, burst or not, gets exactly one `ta` beat with `tbi` high, in the cycle after the request.
- R5: A low address (bits [31:30] = 00, overlay ended) selects bank k when size_k is nonzero and start_k <= address < start_k + size_k. The comparison uses a 33-bit sum. When banks overlap, the lowest index wins. `bank_off` is the address minus start_k, and `bank_sel` is one-hot with bit k set.
- R6: A single RAM transfer gets one `ta` beat in the cycle after the request. A burst RAM transfer gets `ta` on four consecutive cycles starting there. `tbi` stays low on RAM beats, and the select and offset are held for every beat.
- R7: A write with address bits [31:28] = 5 is a register write. Bank index = address bits [4:3]; address bit 2 = 0 picks the start register and 1 picks the size register; the value is `wdata`. It gets one `ta` beat with no select, and the new value applies from the next transfer. Reads in that region, and addresses that match nothing, get no `ta`.
- R8: `ci` is low at all times.
- R9: A request raised while a burst acknowledge is still running is ignored. It gets no extra beats and changes no register and no overlay state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts | input | 1 | Transfer start, one cycle |
| addr | input | 32 | Transfer byte address |
| wr | input | 1 | 1 = write transfer |
| burst | input | 1 | 1 = line (burst) request |
| wdata | input | 32 | Write data, used by register writes |
| ta | output | 1 | Transfer acknowledge |
| tbi | output | 1 | Transfer burst inhibit, only with ROM acknowledge |
| ci | output | 1 | Cache inhibit, always low |
| rom_sel | output | 1 | ROM selected for the current beat(s) |
| rom_word | output | 18 | ROM longword index |
| bank_sel | output | 4 | One-hot DRAM bank select |
| bank_off | output | 32 | Byte offset inside the selected bank |

## Verification
The key coincidence is the overlay-ending transfer: one accepted request is both a ROM access terminated with burst-inhibit and the event that switches the decode of address zero from ROM to DRAM. The bench issues a burst read at 0x4000_0008 while a bank is already mapped at zero. It checks that this transfer gets exactly one beat with `tbi` high, and that the very next request to address zero lands in bank 0 without any ROM select. A second coincidence is a register write issued while a RAM burst is still acknowledging. The bench judges it by the burst's beat count and by decoding the same address afterwards, which shows whether the bank size was changed.

// File: rtl/memdec_pkg.sv
package memdec_pkg;

  localparam int unsigned AW = 32;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_ROM  = 2'd1,
    KIND_RAM  = 2'd2,
    KIND_REG  = 2'd3
  } xfer_kind_e;

  // Half-open window test done in 33 bits so start+size cannot wrap.
  function automatic logic in_window(input logic [AW-1:0] a,
                                     input logic [AW-1:0] base,
                                     input logic [AW-1:0] span);
    logic [AW:0] limit;
    limit = {1'b0, base} + {1'b0, span};
    return (span != '0) && (a >= base) && ({1'b0, a} < limit);
  endfunction

  // Four-bit region tag of an address.
  function automatic logic [3:0] region_of(input logic [AW-1:0] a);
    return a[AW-1 -: 4];
  endfunction

endpackage

// File: rtl/memdec_bank_regs.sv
module memdec_bank_regs
  import memdec_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  localparam int unsigned IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_bank,
  input  logic                           wr_is_size,
  input  logic [AW-1:0]                  wr_data,
  output logic [NUM_BANKS-1:0][AW-1:0]   start_o,
  output logic [NUM_BANKS-1:0][AW-1:0]   size_o
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit_me;
    assign hit_me = wr_en && (wr_bank == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        start_o[g] <= '0;
        size_o[g]  <= '0;
      end else if (hit_me) begin
        if (wr_is_size) size_o[g]  <= wr_data;
        else            start_o[g] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/memdec_bank_match.sv
module memdec_bank_match
  import memdec_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4
) (
  input  logic [AW-1:0]                 addr,
  input  logic                          enable,
  input  logic [NUM_BANKS-1:0][AW-1:0]  start_i,
  input  logic [NUM_BANKS-1:0][AW-1:0]  size_i,
  output logic [NUM_BANKS-1:0]          hit_onehot,
  output logic                          any_hit,
  output logic [AW-1:0]                 offset
);

  logic [NUM_BANKS-1:0] raw_hit;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_cmp
    assign raw_hit[g] = enable && in_window(addr, start_i[g], size_i[g]);
  end

  // Lowest index wins when windows overlap.
  always_comb begin
    hit_onehot = '0;
    offset     = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (raw_hit[i]) begin
        hit_onehot    = '0;
        hit_onehot[i] = 1'b1;
        offset        = addr - start_i[i];
      end
    end
  end

  assign any_hit = |raw_hit;

endmodule

// File: rtl/memdec_overlay.sv
module memdec_overlay (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_req,
  output logic active
);

  always_ff @(posedge clk) begin
    if (!rst_n)         active <= 1'b1;
    else if (clear_req) active <= 1'b0;
  end

endmodule

// File: rtl/memdec_term.sv
module memdec_term
  import memdec_pkg::*;
#(
  parameter int unsigned BURST_BEATS = 4,
  localparam int unsigned LEFT_W = (BURST_BEATS > 2) ? $clog2(BURST_BEATS) : 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  xfer_kind_e kind,
  input  logic       burst,
  output logic       ta,
  output logic       tbi,
  output logic       busy
);

  logic [LEFT_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ta     <= 1'b0;
      tbi    <= 1'b0;
      left_q <= '0;
    end else if (start) begin
      ta     <= 1'b1;
      tbi    <= (kind == KIND_ROM);
      left_q <= (kind == KIND_RAM && burst) ? LEFT_W'(BURST_BEATS - 1) : '0;
    end else if (left_q != '0) begin
      ta     <= 1'b1;
      tbi    <= 1'b0;
      left_q <= left_q - 1'b1;
    end else begin
      ta     <= 1'b0;
      tbi    <= 1'b0;
    end
  end

  assign busy = (left_q != '0);

endmodule

// File: rtl/memdec_top.sv
module memdec_top
  import memdec_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 4,
  parameter int unsigned ROM_AW      = 18,
  parameter int unsigned BURST_BEATS = 4,
  parameter logic [3:0]  ROM_REGION  = 4'h4,
  parameter logic [3:0]  REG_REGION  = 4'h5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ts,
  input  logic [31:0]          addr,
  input  logic                 wr,
  input  logic                 burst,
  input  logic [31:0]          wdata,
  output logic                 ta,
  output logic                 tbi,
  output logic                 ci,
  output logic                 rom_sel,
  output logic [ROM_AW-1:0]    rom_word,
  output logic [NUM_BANKS-1:0] bank_sel,
  output logic [31:0]          bank_off
);

  localparam int unsigned IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned ROM_BITS = ROM_AW + 2;

  // Named internal events (used by the bound checker).
  logic       overlay_active;
  logic       busy;
  logic       accept;
  logic       ovl_clear;
  logic       reg_write;
  xfer_kind_e kind;

  logic                          in_rom_region, in_reg_region, in_low;
  logic                          ovl_alias, reg_ok;
  logic [IDX_W-1:0]              reg_bank;
  logic [NUM_BANKS-1:0][AW-1:0]  bank_start, bank_size;
  logic [NUM_BANKS-1:0]          hit_onehot;
  logic                          any_hit;
  logic [AW-1:0]                 hit_off;

  assign in_rom_region = (region_of(addr) == ROM_REGION);
  assign in_reg_region = (region_of(addr) == REG_REGION);
  assign in_low        = (addr[AW-1 -: 2] == 2'b00);
  assign ovl_alias     = overlay_active && (addr[AW-1:ROM_BITS] == '0);
  assign reg_bank      = addr[3 +: IDX_W];
  assign reg_ok        = in_reg_region && wr &&
                         ({1'b0, reg_bank} < (IDX_W+1)'(NUM_BANKS));

  memdec_bank_match #(.NUM_BANKS(NUM_BANKS)) u_match (
    .addr       (addr),
    .enable     (in_low && !overlay_active),
    .start_i    (bank_start),
    .size_i     (bank_size),
    .hit_onehot (hit_onehot),
    .any_hit    (any_hit),
    .offset     (hit_off)
  );

  always_comb begin
    if (ovl_alias || in_rom_region) kind = KIND_ROM;
    else if (any_hit)               kind = KIND_RAM;
    else if (reg_ok)                kind = KIND_REG;
    else                            kind = KIND_NONE;
  end

  assign accept    = ts && !busy;
  assign ovl_clear = accept && in_rom_region;
  assign reg_write = accept && (kind == KIND_REG);

  memdec_overlay u_ovl (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_req (ovl_clear),
    .active    (overlay_active)
  );

  memdec_bank_regs #(.NUM_BANKS(NUM_BANKS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_write),
    .wr_bank    (reg_bank),
    .wr_is_size (addr[2]),
    .wr_data    (wdata),
    .start_o    (bank_start),
    .size_o     (bank_size)
  );

  memdec_term #(.BURST_BEATS(BURST_BEATS)) u_term (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept && (kind != KIND_NONE)),
    .kind  (kind),
    .burst (burst),
    .ta    (ta),
    .tbi   (tbi),
    .busy  (busy)
  );

  // Selects follow the acknowledge beats: loaded on accept, held while
  // beats remain, dropped when the sequence ends.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rom_sel  <= 1'b0;
      rom_word <= '0;
      bank_sel <= '0;
      bank_off <= '0;
    end else if (accept) begin
      rom_sel  <= (kind == KIND_ROM);
      rom_word <= addr[ROM_BITS-1:2];
      bank_sel <= (kind == KIND_RAM) ? hit_onehot : '0;
      bank_off <= hit_off;
    end else if (!busy) begin
      rom_sel  <= 1'b0;
      bank_sel <= '0;
    end
  end

  assign ci = 1'b0;

endmodule

// File: rtl/memdec_checker.sv
module memdec_checker #(
  parameter int unsigned NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ts,
  input logic                 ta,
  input logic                 tbi,
  input logic                 rom_sel,
  input logic [NUM_BANKS-1:0] bank_sel,
  input logic                 overlay_active,
  input logic                 ovl_clear,
  input logic                 busy
);

  // R4
  rom_tbi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel && ta) |-> tbi);

  // R6
  ram_no_tbi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_sel) |-> !tbi);

  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, bank_sel}));

  // R3
  ovl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_clear |=> !overlay_active);

  // R3
  ovl_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !overlay_active |=> !overlay_active);

  // R2
  ovl_no_ram_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overlay_active |-> (bank_sel == '0));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ts && busy) |=> (ta && !tbi && $stable({rom_sel, bank_sel})));

endmodule

bind memdec_top memdec_checker #(.NUM_BANKS(NUM_BANKS)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .ts             (ts),
  .ta             (ta),
  .tbi            (tbi),
  .rom_sel        (rom_sel),
  .bank_sel       (bank_sel),
  .overlay_active (overlay_active),
  .ovl_clear      (ovl_clear),
  .busy           (busy)
);

// File: tb/memdec_top_tb_top.sv
`timescale 1ns/1ps
module memdec_top_tb_top;

  localparam int K_NONE = 0, K_ROM = 1, K_RAM = 2, K_REG = 3;
  localparam int NV = 10;
  // {addr, wr, burst, kind[1:0], bank[1:0], value}
  localparam logic [69:0] VEC [NV] = '{
    {32'h0000_0100, 1'b0, 1'b0, 2'd2, 2'd0, 32'h0000_0100},
    {32'h007F_FFFC, 1'b0, 1'b0, 2'd2, 2'd0, 32'h007F_FFFC},
    {32'h0080_0000, 1'b0, 1'b0, 2'd2, 2'd1, 32'h0000_0000},
    {32'h0100_0000, 1'b0, 1'b1, 2'd2, 2'd2, 32'h0000_0000},
    {32'h0140_0000, 1'b0, 1'b0, 2'd0, 2'd0, 32'h0000_0000},
    {32'h4010_0004, 1'b0, 1'b0, 2'd1, 2'd0, 32'h0000_0001},
    {32'h400F_FFFC, 1'b0, 1'b1, 2'd1, 2'd0, 32'h0003_FFFF},
    {32'h5000_0000, 1'b0, 1'b0, 2'd0, 2'd0, 32'h0000_0000},
    {32'h6000_0000, 1'b0, 1'b0, 2'd0, 2'd0, 32'h0000_0000},
    {32'h0000_0000, 1'b0, 1'b1, 2'd2, 2'd0, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ts = 1'b0, wr = 1'b0, burst = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic        ta, tbi, ci, rom_sel;
  logic [17:0] rom_word;
  logic [3:0]  bank_sel;
  logic [31:0] bank_off;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  memdec_top dut_i (
    .clk(clk), .rst_n(rst_n), .ts(ts), .addr(addr), .wr(wr), .burst(burst),
    .wdata(wdata), .ta(ta), .tbi(tbi), .ci(ci), .rom_sel(rom_sel),
    .rom_word(rom_word), .bank_sel(bank_sel), .bank_off(bank_off)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] strobes();
    return {ta, tbi, ci, rom_sel, bank_sel};
  endfunction

  // One transfer: request for one cycle, then each expected beat is checked,
  // then the idle cycle after the last beat.
  task automatic xfer(input logic [31:0] a, input logic w, input logic b,
                      input logic [31:0] d, input int kind, input int bank,
                      input logic [31:0] val, input string req);
    int beats;
    logic [7:0] exp_s;
    beats = (kind == K_NONE) ? 0 : ((kind == K_RAM && b) ? 4 : 1);
    exp_s = {1'b1, (kind == K_ROM), 1'b0, (kind == K_ROM),
             (kind == K_RAM) ? 4'(1 << bank) : 4'b0};
    @(negedge clk);
    ts = 1'b1; addr = a; wr = w; burst = b; wdata = d;
    @(negedge clk);
    ts = 1'b0;
    for (int i = 0; i < beats; i++) begin
      check(req, 64'(strobes()), 64'(exp_s));
      if (kind == K_ROM) check(req, 64'(rom_word), 64'(val));
      if (kind == K_RAM) check(req, 64'(bank_off), 64'(val));
      @(negedge clk);
    end
    check(req, 64'(strobes()), 64'h0);
  endtask

  task automatic wr_reg(input int bank, input bit is_size, input logic [31:0] d);
    xfer(32'h5000_0000 | 32'(bank << 3) | 32'(is_size << 2), 1'b1, 1'b0, d,
         K_REG, 0, 0, "R7 register write");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1, R8: reset state
    check("R1 reset strobes", 64'(strobes()), 64'h0);
    check("R8 ci low", 64'(ci), 64'h0);

    // R2: overlay aliases ROM at bottom, burst refused with tbi (R4)
    xfer(32'h0000_0010, 1'b0, 1'b1, 0, K_ROM, 0, 32'h4, "R2 overlay rom alias");
    xfer(32'h0020_0000, 1'b0, 1'b0, 0, K_NONE, 0, 0, "R2 overlay ram disabled");

    // R7: map banks while overlay is still active
    wr_reg(0, 1'b0, 32'h0000_0000); wr_reg(0, 1'b1, 32'h0080_0000);
    wr_reg(1, 1'b0, 32'h0080_0000); wr_reg(1, 1'b1, 32'h0080_0000);
    wr_reg(2, 1'b0, 32'h0100_0000); wr_reg(2, 1'b1, 32'h0040_0000);
    xfer(32'h0000_0000, 1'b0, 1'b0, 0, K_ROM, 0, 0, "R2 zero still rom in overlay");

    // R3: ROM-region burst clears overlay; next access at zero hits bank 0
    xfer(32'h4000_0008, 1'b0, 1'b1, 0, K_ROM, 0, 32'h2, "R3 overlay exit rom beat");
    xfer(32'h0000_0000, 1'b0, 1'b0, 0, K_RAM, 0, 0, "R3 zero now bank0");

    // Table walk: R4 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      xfer(VEC[v][69:38], VEC[v][37], VEC[v][36], 32'h0,
           int'(VEC[v][35:34]), int'(VEC[v][33:32]), VEC[v][31:0],
           "R5/R6/R4 table vector");
    end

    // R5: enabling bank3 and overlap priority
    wr_reg(3, 1'b0, 32'h0140_0000); wr_reg(3, 1'b1, 32'h0010_0000);
    xfer(32'h0140_0000, 1'b0, 1'b0, 0, K_RAM, 3, 0, "R5 bank3 enabled");
    wr_reg(2, 1'b1, 32'h0050_0000);
    xfer(32'h0140_0000, 1'b0, 1'b0, 0, K_RAM, 2, 32'h0040_0000, "R5 lowest index wins");

    // R9: register write raised during a RAM burst is ignored
    @(negedge clk);
    ts = 1'b1; addr = 32'h0000_0100; wr = 1'b0; burst = 1'b1;
    @(negedge clk);
    ts = 1'b1; addr = 32'h5000_0004; wr = 1'b1; burst = 1'b0; wdata = 32'h0;
    check("R9 burst beat1", 64'(strobes()), 64'h81);
    @(negedge clk);
    ts = 1'b0;
    check("R9 burst beat2", 64'(strobes()), 64'h81);
    @(negedge clk);
    check("R9 burst beat3", 64'(strobes()), 64'h81);
    @(negedge clk);
    check("R9 burst beat4", 64'(strobes()), 64'h81);
    @(negedge clk);
    check("R9 no extra beat", 64'(strobes()), 64'h0);
    xfer(32'h0000_0100, 1'b0, 1'b0, 0, K_RAM, 0, 32'h100, "R9 bank0 size unchanged");

    // R3: overlay does not come back; R8 ci still low
    xfer(32'h0000_0010, 1'b0, 1'b0, 0, K_RAM, 0, 32'h10, "R3 overlay stays off");
    check("R8 ci low at end", 64'(ci), 64'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule